// File: doc/BRIEF.md
# Per-Color Dark-Level Offset Corrector

This block sits behind the digitizer of a three-color linear image sensor. Each incoming sample carries a two-bit color code, a two-bit pixel class and a start-of-line flag. Each color has its own dark level. For every line and every color, the block averages that color's shielded (dark-reference) pixels into a per-color offset register. It then subtracts that color's offset from the color's active pixels. The results go out as a one-cycle-delayed stream of corrected pixels, clamped at zero.

There are three independent lanes, one per color. Each lane has its own accumulator, counters and offset register, so the block works the same whether the colors arrive in separate lines or interleaved within each pixel period. A lane loads a new offset only once its dark window for the line is complete. Until then, pixels are corrected with the offset from the previous line. The three offsets are visible on output ports.

Top module: `obc_offset_corrector`

## Requirements
- R1: Color codes map as 2'b01 red, 2'b10 green, 2'b11 blue. Each lane's offset is presented on `off_red`, `off_green` or `off_blue`, and `out_color` repeats the code of the corrected sample.
- R2: A sample with `in_valid` high and color code 2'b00 is dropped. `color_err` pulses high in the following cycle, no pixel is emitted, and no lane state changes.
- R3: Pixel class encoding is 2'b01 dark reference and 2'b10 active. Samples of class 2'b00 or 2'b11 are ignored: they produce no output and do not enter any accumulator.
- R4: When a color receives its 48th dark sample of a line, its offset becomes min((S*43)>>11, 4095), where S is the sum of those 48 samples. The new offset is visible on the offset port after the clock edge that accepts that sample.
- R5: Dark samples beyond the 48th of a color within a line are ignored.
- R6: After reset all offsets are zero. Active pixels that arrive before a color's window completes use the offset that color held from earlier lines.
- R7: Each accepted active pixel appears one cycle later as `out_pixel` = sample minus its color's offset, or 0 when the offset is not smaller than the sample, with `out_valid` high.
- R8: At most 2700 active pixels per color per line are emitted. Further active pixels of that color in the line are dropped, and other colors are not affected.
- R9: A valid sample with `in_sol` high restarts all per-line counts and sums and then counts as the first sample of the new line. A window left incomplete by a new line does not change the offset.
- R10: The lanes are independent. Samples of one color never change another color's offset or counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 12 | Digitized sample |
| in_color | input | 2 | Color code (01 red, 10 green, 11 blue) |
| in_class | input | 2 | Pixel class (01 dark reference, 10 active) |
| in_sol | input | 1 | First sample of a line |
| out_valid | output | 1 | Corrected pixel strobe |
| out_pixel | output | 12 | Corrected pixel, clamped at zero |
| out_color | output | 2 | Color code of the corrected pixel |
| color_err | output | 1 | Pulse for a dropped sample with code 00 |
| off_red | output | 12 | Current red offset |
| off_green | output | 12 | Current green offset |
| off_blue | output | 12 | Current blue offset |

## Verification
Several properties are checked on every cycle. Offsets stay still unless a dark sample arrives, and code 00 always drops its sample and raises the error pulse. Every output comes from an active input one cycle earlier and keeps its color code. A corrected value never exceeds its input sample and is zero when the offset covers the sample. The numeric averaging can only be shown by the bench's scenarios: the 48-sample window limit, the 2700-pixel cap, the restart at a new line and saturation at full scale. The same holds for the rule that an incomplete window leaves the old offset in place.

// File: rtl/obc_pkg.sv
package obc_pkg;
    localparam int NUM_COLORS = 3;

    typedef enum logic [1:0] {
        CLS_DUMMY  = 2'b00,
        CLS_DARK   = 2'b01,
        CLS_ACTIVE = 2'b10,
        CLS_SPARE  = 2'b11
    } pix_class_e;

    // lane index of a color code: 01 -> 0 (red), 10 -> 1 (green), 11 -> 2 (blue)
    function automatic logic [1:0] color_index(input logic [1:0] code);
        return code - 2'd1;
    endfunction
endpackage

// File: rtl/obc_decode.sv
module obc_decode
    import obc_pkg::*;
(
    input  logic                  valid_i,
    input  logic [1:0]            code_i,
    input  logic [1:0]            class_i,
    output logic [NUM_COLORS-1:0] hit_o,
    output logic                  dark_o,
    output logic                  active_o,
    output logic                  code_err_o
);
    assign code_err_o = valid_i && (code_i == 2'b00);
    assign dark_o     = (class_i == CLS_DARK);
    assign active_o   = (class_i == CLS_ACTIVE);

    for (genvar g = 0; g < NUM_COLORS; g++) begin : g_hit
        assign hit_o[g] = valid_i && (code_i == 2'(g + 1));
    end
endmodule

// File: rtl/obc_lane.sv
module obc_lane #(
    parameter int DW          = 12,
    parameter int OB_PIX      = 48,
    parameter int ACT_PIX     = 2700,
    parameter int SCALE_MUL   = 43,
    parameter int SCALE_SHIFT = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sol_i,
    input  logic          hit_i,
    input  logic          dark_i,
    input  logic          active_i,
    input  logic [DW-1:0] sample_i,
    output logic [DW-1:0] offset_o,
    output logic          emit_o
);
    localparam int ACCW  = DW + $clog2(OB_PIX);
    localparam int MULW  = $clog2(SCALE_MUL + 1);
    localparam int PW    = ACCW + MULW;
    localparam int OBCW  = $clog2(OB_PIX + 1);
    localparam int ACTCW = $clog2(ACT_PIX + 1);

    localparam logic [OBCW-1:0]  OB_END  = OBCW'(OB_PIX);
    localparam logic [OBCW-1:0]  OB_LAST = OBCW'(OB_PIX - 1);
    localparam logic [ACTCW-1:0] ACT_END = ACTCW'(ACT_PIX);
    localparam logic [PW-1:0]    SAT     = PW'((1 << DW) - 1);
    localparam logic [PW-1:0]    MULV    = PW'(SCALE_MUL);

    typedef struct packed {
        logic [ACCW-1:0]  acc;
        logic [OBCW-1:0]  ob_cnt;
        logic [ACTCW-1:0] act_cnt;
        logic [DW-1:0]    offset;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [ACCW-1:0]  acc_base, sum;
    logic [OBCW-1:0]  ob_base;
    logic [ACTCW-1:0] act_base;
    logic [PW-1:0]    scaled;

    always_comb begin
        st_d     = st_q;
        emit_o   = 1'b0;
        acc_base = sol_i ? '0 : st_q.acc;
        ob_base  = sol_i ? '0 : st_q.ob_cnt;
        act_base = sol_i ? '0 : st_q.act_cnt;
        sum      = acc_base + ACCW'(sample_i);
        scaled   = (PW'(sum) * MULV) >> SCALE_SHIFT;

        st_d.acc     = acc_base;
        st_d.ob_cnt  = ob_base;
        st_d.act_cnt = act_base;

        if (hit_i && dark_i && (ob_base < OB_END)) begin
            st_d.acc    = sum;
            st_d.ob_cnt = ob_base + 1'b1;
            if (ob_base == OB_LAST) begin
                st_d.offset = (scaled > SAT) ? DW'(SAT) : scaled[DW-1:0];
            end
        end

        if (hit_i && active_i && (act_base < ACT_END)) begin
            st_d.act_cnt = act_base + 1'b1;
            emit_o       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign offset_o = st_q.offset;
endmodule

// File: rtl/obc_subtract.sv
module obc_subtract #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic          err_i,
    input  logic [1:0]    code_i,
    input  logic [DW-1:0] sample_i,
    input  logic [DW-1:0] offset_i,
    output logic          valid_o,
    output logic [DW-1:0] pixel_o,
    output logic [1:0]    code_o,
    output logic          err_o
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] pixel;
        logic [1:0]    code;
        logic          err;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = fire_i;
        st_d.err   = err_i;
        if (fire_i) begin
            st_d.code  = code_i;
            st_d.pixel = (sample_i > offset_i) ? (sample_i - offset_i) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign pixel_o = st_q.pixel;
    assign code_o  = st_q.code;
    assign err_o   = st_q.err;
endmodule

// File: rtl/obc_offset_corrector.sv
module obc_offset_corrector
    import obc_pkg::*;
#(
    parameter int DW          = 12,
    parameter int OB_PIX      = 48,
    parameter int ACT_PIX     = 2700,
    parameter int SCALE_MUL   = 43,
    parameter int SCALE_SHIFT = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic [1:0]    in_color,
    input  logic [1:0]    in_class,
    input  logic          in_sol,
    output logic          out_valid,
    output logic [DW-1:0] out_pixel,
    output logic [1:0]    out_color,
    output logic          color_err,
    output logic [DW-1:0] off_red,
    output logic [DW-1:0] off_green,
    output logic [DW-1:0] off_blue
);
    logic [NUM_COLORS-1:0] hit, emit;
    logic                  is_dark, is_active, code_err, line_start;
    logic [DW-1:0]         lane_off [NUM_COLORS];
    logic [DW-1:0]         sel_off;

    obc_decode u_dec (
        .valid_i    (in_valid),
        .code_i     (in_color),
        .class_i    (in_class),
        .hit_o      (hit),
        .dark_o     (is_dark),
        .active_o   (is_active),
        .code_err_o (code_err)
    );

    assign line_start = in_valid && in_sol && !code_err;

    for (genvar g = 0; g < NUM_COLORS; g++) begin : g_lane
        obc_lane #(
            .DW          (DW),
            .OB_PIX      (OB_PIX),
            .ACT_PIX     (ACT_PIX),
            .SCALE_MUL   (SCALE_MUL),
            .SCALE_SHIFT (SCALE_SHIFT)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sol_i    (line_start),
            .hit_i    (hit[g]),
            .dark_i   (is_dark),
            .active_i (is_active),
            .sample_i (in_sample),
            .offset_o (lane_off[g]),
            .emit_o   (emit[g])
        );
    end

    always_comb begin
        case (color_index(in_color))
            2'd0:    sel_off = lane_off[0];
            2'd1:    sel_off = lane_off[1];
            2'd2:    sel_off = lane_off[2];
            default: sel_off = '0;
        endcase
    end

    obc_subtract #(.DW(DW)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (|emit),
        .err_i    (code_err),
        .code_i   (in_color),
        .sample_i (in_sample),
        .offset_i (sel_off),
        .valid_o  (out_valid),
        .pixel_o  (out_pixel),
        .code_o   (out_color),
        .err_o    (color_err)
    );

    assign off_red   = lane_off[0];
    assign off_green = lane_off[1];
    assign off_blue  = lane_off[2];
endmodule

// File: rtl/obc_offset_corrector_chk.sv
module obc_offset_corrector_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_sample,
    input logic [1:0]    in_color,
    input logic [1:0]    in_class,
    input logic          out_valid,
    input logic [DW-1:0] out_pixel,
    input logic [1:0]    out_color,
    input logic          color_err,
    input logic [DW-1:0] off_red,
    input logic [DW-1:0] off_green,
    input logic [DW-1:0] off_blue
);
    logic [DW-1:0] cur_off;

    always_comb begin
        case (in_color)
            2'b01:   cur_off = off_red;
            2'b10:   cur_off = off_green;
            2'b11:   cur_off = off_blue;
            default: cur_off = '0;
        endcase
    end

    AST_BAD_CODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_color == 2'b00) |=> (color_err && !out_valid)); // R2

    AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_class == 2'b01) |=> ($stable(off_red) && $stable(off_green) && $stable(off_blue))); // R3

    AST_OUT_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_class == 2'b10 && in_color != 2'b00)); // R7

    AST_COLOR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_color == $past(in_color))); // R1

    AST_NOT_ABOVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pixel <= $past(in_sample))); // R7

    AST_ZERO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_sample) <= $past(cur_off)) |-> (out_pixel == '0)); // R7
endmodule

bind obc_offset_corrector obc_offset_corrector_chk #(.DW(DW)) u_chk (.*);

// File: tb/obc_offset_corrector_tb.sv
module obc_offset_corrector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [1:0]  in_color = '0;
    logic [1:0]  in_class = '0;
    logic        in_sol = 1'b0;
    logic        out_valid, color_err;
    logic [11:0] out_pixel, off_red, off_green, off_blue;
    logic [1:0]  out_color;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    localparam logic [1:0] RED = 2'b01, GRN = 2'b10, BLU = 2'b11;
    localparam logic [1:0] DARK = 2'b01, ACT = 2'b10;

    obc_offset_corrector u_dut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int exp_off(int s);
        int v = (s * 43) >>> 11;
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one sample; outputs for it are visible on return
    task automatic push(int s, logic [1:0] c, logic [1:0] k, logic sol);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 12'(s); in_color = c; in_class = k; in_sol = sol;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset off_red", off_red, 0);
        chk("R6 reset off_green", off_green, 0);
        chk("R6 reset off_blue", off_blue, 0);
        chk("R7 reset out_valid", out_valid, 0);
    endtask

    task automatic t_interleaved(output int o_r, output int o_g, output int o_b);
        int sr = 0, sg = 0, sb = 0;
        push(777, RED, ACT, 1'b1);
        chk("R6 pre-window zero offset", out_pixel, 777);
        chk("R1 out_color red", out_color, 1);
        for (int i = 0; i < 48; i++) begin
            push(100 + i, RED, DARK, 1'b0);       sr += 100 + i;
            push(400 + 2 * i, GRN, DARK, 1'b0);   sg += 400 + 2 * i;
            push(30 + (i % 5), BLU, DARK, 1'b0);  sb += 30 + (i % 5);
        end
        o_r = exp_off(sr); o_g = exp_off(sg); o_b = exp_off(sb);
        chk("R4 R10 red offset", off_red, o_r);
        chk("R4 R10 green offset", off_green, o_g);
        chk("R4 R10 blue offset", off_blue, o_b);
        push(1000, RED, ACT, 1'b0);
        chk("R7 red corrected", out_pixel, 1000 - o_r);
        chk("R7 red valid", out_valid, 1);
        push(50, GRN, ACT, 1'b0);
        chk("R7 green clamp", out_pixel, 0);
        chk("R1 out_color green", out_color, 2);
        push(o_b, BLU, ACT, 1'b0);
        chk("R7 blue equal clamp", out_pixel, 0);
        push(o_b + 9, BLU, ACT, 1'b0);
        chk("R7 blue corrected", out_pixel, 9);
        chk("R1 out_color blue", out_color, 3);
    endtask

    task automatic t_bad_code(int prev_r);
        push(50, RED, DARK, 1'b1);
        for (int i = 0; i < 10; i++) push(50, RED, DARK, 1'b0);
        push(4000, 2'b00, DARK, 1'b0);
        chk("R2 color_err pulse", color_err, 1);
        chk("R2 no output", out_valid, 0);
        push(4000, 2'b00, ACT, 1'b0);
        chk("R2 active dropped", out_valid, 0);
        chk("R6 offset held mid-window", off_red, prev_r);
        for (int i = 0; i < 37; i++) push(50, RED, DARK, 1'b0);
        chk("R2 color_err cleared", color_err, 0);
        chk("R2 bad sample excluded", off_red, exp_off(48 * 50));
    endtask

    task automatic t_classes();
        push(200, GRN, DARK, 1'b1);
        for (int i = 0; i < 9; i++) push(200, GRN, DARK, 1'b0);
        push(4000, GRN, 2'b11, 1'b0);
        chk("R3 spare class no output", out_valid, 0);
        push(4000, GRN, 2'b00, 1'b0);
        chk("R3 dummy class no output", out_valid, 0);
        for (int i = 0; i < 38; i++) push(200, GRN, DARK, 1'b0);
        chk("R3 ignored classes not summed", off_green, exp_off(48 * 200));
    endtask

    task automatic t_extra_dark();
        push(300, RED, DARK, 1'b1);
        for (int i = 0; i < 47; i++) push(300, RED, DARK, 1'b0);
        chk("R5 window offset", off_red, exp_off(48 * 300));
        for (int i = 0; i < 5; i++) push(4000, RED, DARK, 1'b0);
        chk("R5 extra dark ignored", off_red, exp_off(48 * 300));
    endtask

    task automatic t_restart();
        int prev_g = off_green;
        push(3000, GRN, DARK, 1'b1);
        for (int i = 0; i < 19; i++) push(3000, GRN, DARK, 1'b0);
        chk("R9 incomplete window keeps offset", off_green, prev_g);
        push(3000, GRN, ACT, 1'b1);
        chk("R6 R9 previous offset used", out_pixel, 3000 - prev_g);
        for (int i = 0; i < 47; i++) push(10, GRN, DARK, 1'b0);
        chk("R9 partial window not yet applied", off_green, prev_g);
        push(10, GRN, DARK, 1'b0);
        chk("R9 fresh window after restart", off_green, exp_off(480));
    endtask

    task automatic t_cap();
        int bad = 0;
        push(2000, RED, ACT, 1'b1);
        if (!out_valid) bad++;
        for (int i = 1; i < 2700; i++) begin
            push(2000, RED, ACT, 1'b0);
            if (!out_valid) bad++;
        end
        chk("R8 first 2700 emitted", bad, 0);
        push(2000, RED, ACT, 1'b0);
        chk("R8 2701st dropped", out_valid, 0);
        push(2000, GRN, ACT, 1'b0);
        chk("R8 R10 other color unaffected", out_valid, 1);
        push(2000, RED, ACT, 1'b1);
        chk("R8 R9 new line re-enables", out_valid, 1);
    endtask

    task automatic t_saturate();
        push(4095, BLU, DARK, 1'b1);
        for (int i = 0; i < 47; i++) push(4095, BLU, DARK, 1'b0);
        chk("R4 saturated offset", off_blue, 4095);
        push(4095, BLU, ACT, 1'b0);
        chk("R7 full-scale clamp", out_pixel, 0);
    endtask

    initial begin
        int o_r, o_g, o_b;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_interleaved(o_r, o_g, o_b);
        t_bad_code(o_r);
        t_classes();
        t_extra_dark();
        t_restart();
        t_cap();
        t_saturate();
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule